// File: doc/BRIEF.md
# Two-Wire Slave Front End with Acknowledge Polling

This block is the serial front end of a slave on a two-wire open-drain bus. It samples the bus clock and data lines in the system clock domain. Each line passes through a two-flop synchronizer and a three-sample majority filter. The block then finds start and stop conditions and frames the traffic into bytes, shifted most significant bit first. The first byte after a start is an 8-bit slave address with no direction bit. Its upper nibble is a fixed type code, 0101. Its lower nibble must match four strap inputs. The block acknowledges the address only when the core is not busy with a nonvolatile store. A bus master can therefore poll the slave with bare address bytes until it is acknowledged again.

After the address the block accepts an instruction byte. It then accepts either one write byte from the master or sends one read byte supplied by the core. The core sees each received byte as a one-cycle strobe, together with the byte value and an index: 0 for the address, 1 for the instruction, 2 for write data. It also sees one-cycle start and stop pulses and a read request pulse. The block only frames the protocol; it does not interpret instructions.

The state machine has the states IDLE, ADDR, ADDR_ACK, INSTR, INSTR_ACK, WDATA, WDATA_ACK, RDATA, RD_MACK and HOLD. Every state goes to ADDR on a start and to IDLE on a stop. The transitions made on an SCL falling edge are:
- ADDR to ADDR_ACK on a match while not busy; ADDR to IDLE otherwise.
- ADDR_ACK to INSTR.
- INSTR to INSTR_ACK.
- INSTR_ACK to RDATA when the read select input is high; INSTR_ACK to WDATA otherwise.
- WDATA to WDATA_ACK.
- WDATA_ACK to HOLD.
- RDATA to RD_MACK after eight bits.
- RD_MACK to HOLD.

HOLD and IDLE leave only on a start or a stop.

Top module: `tw_slave_fe`

## Requirements
- R1: Out of reset the data pull is released. Bus activity seen before any start condition gives no acknowledge and no byte strobe.
- R2: Every start condition (SDA falling while SCL is high) gives one start_o pulse. Every stop condition (SDA rising while SCL is high) gives one stop_o pulse and returns the block to idle.
- R3: An address byte equal to {4'b0101, strap_i} is acknowledged: SDA is held low through the ninth SCL clock. The address also gives a strobe with byte_idx_o = 0 and byte_o equal to the address.
- R4: An address byte that does not match is not acknowledged. No strobe and no acknowledge follow until the next start.
- R5: A matching address is not acknowledged while busy_i is high. The first matching address after busy_i falls is acknowledged.
- R6: The byte after an acknowledged address is acknowledged and strobed with byte_idx_o = 1.
- R7: When rd_sel_i is low at the end of the instruction acknowledge, the next byte is acknowledged and strobed with byte_idx_o = 2. Any later byte before a stop is neither acknowledged nor strobed.
- R8: When rd_sel_i is high at the end of the instruction acknowledge, rd_req_o pulses once and rd_data_i is sent MSB first. SDA is then released for the master's ninth bit.
- R9: SDA is only pulled low or released. The pull changes only while SCL is low.
- R10: A repeated start in the middle of a byte abandons the transfer. The next byte is treated as an address and the byte after it as the instruction (index 1).
- R11: An SCL pulse lasting one system clock is filtered out and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 4 | Strapped low address nibble |
| busy_i | input | 1 | Core store cycle in progress; address is refused |
| rd_sel_i | input | 1 | Sampled at instruction acknowledge end: 1 selects a read byte |
| rd_data_i | input | 8 | Byte to send for a read |
| rd_req_o | output | 1 | One-cycle pulse when rd_data_i is captured |
| byte_vld_o | output | 1 | One-cycle strobe for a received and acknowledged byte |
| byte_o | output | 8 | Received byte value |
| byte_idx_o | output | 2 | 0 address, 1 instruction, 2 write data |
| start_o | output | 1 | Start condition pulse |
| stop_o | output | 1 | Stop condition pulse |

## Verification
Two functions can meet on the same SCL falling edge. One is the address compare, which can refuse an address because busy_i is high. The other is the end of a previous acknowledge. The bench provokes this with acknowledge polling: it sends a matching address while busy, then lowers busy and sends the address again. Random transactions assert busy about a quarter of the time and mix matching and mismatching addresses. The bench judges each outcome by the acknowledge bit sampled in the ninth clock and by the count of strobes. A second collision comes from a repeated start arriving in the middle of a byte. The bench checks that the next byte is strobed as an address and the byte after it with index 1.

// File: rtl/twfe_pkg.sv
package twfe_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_MACK,
        ST_HOLD
    } fe_state_t;

    localparam logic [1:0] IDX_ADDR  = 2'd0;
    localparam logic [1:0] IDX_INSTR = 2'd1;
    localparam logic [1:0] IDX_DATA  = 2'd2;
endpackage

// File: rtl/twfe_filter.sv
module twfe_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3,
    parameter bit          IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned HALF = FILT_LEN / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    win_q;
    logic                   out_q;
    logic                   vote;

    assign vote = ($countones(win_q) > HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
            win_q  <= {FILT_LEN{IDLE_LEVEL}};
            out_q  <= IDLE_LEVEL;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            out_q  <= vote;
        end
    end

    assign dout = out_q;

    // R11: the filtered level may only change once most of the window agrees with it
    assert_filter_majority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> ($countones($past(win_q)) > HALF) == out_q);
endmodule

// File: rtl/twfe_cond.sv
module twfe_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_p,
    output logic stop_p,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign start_p  = scl_d & scl_f & sda_d & ~sda_f;
    assign stop_p   = scl_d & scl_f & ~sda_d & sda_f;
    assign scl_rise = ~scl_d & scl_f;
    assign scl_fall = scl_d & ~scl_f;
endmodule

// File: rtl/twfe_fsm.sv
module twfe_fsm
    import twfe_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned STRAP_W = 4,
    parameter int unsigned TYPE_ID = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_p,
    input  logic               stop_p,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               scl_f,
    input  logic               sda_f,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic               rd_sel_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               sda_pull_o,
    output logic               rd_req_o,
    output logic               byte_vld_o,
    output logic [DATA_W-1:0]  byte_o,
    output logic [1:0]         byte_idx_o
);
    localparam int unsigned TYPE_W = DATA_W - STRAP_W;
    localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    fe_state_t         state_q, state_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              pull_q, pull_d;
    logic              vld_q, vld_d;
    logic              req_q, req_d;
    logic [DATA_W-1:0] byte_q, byte_d;
    logic [1:0]        idx_q, idx_d;
    logic              addr_hit;

    assign addr_hit = (sh_q == {TYPE_W'(TYPE_ID), strap_i});

    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        cnt_d   = cnt_q;
        pull_d  = pull_q;
        vld_d   = 1'b0;
        req_d   = 1'b0;
        byte_d  = byte_q;
        idx_d   = idx_q;
        if (start_p) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
            pull_d  = 1'b0;
        end else if (stop_p) begin
            state_d = ST_IDLE;
            pull_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HOLD: begin
                end
                ST_ADDR, ST_INSTR, ST_WDATA: begin
                    if (scl_rise && cnt_q < CNT_FULL) begin
                        sh_d  = {sh_q[DATA_W-2:0], sda_f};
                        cnt_d = cnt_q + CNT_ONE;
                    end else if (scl_fall && cnt_q == CNT_FULL) begin
                        cnt_d  = '0;
                        byte_d = sh_q;
                        if (state_q == ST_ADDR) begin
                            if (addr_hit && !busy_i) begin
                                state_d = ST_ADDR_ACK;
                                pull_d  = 1'b1;
                                vld_d   = 1'b1;
                                idx_d   = IDX_ADDR;
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end else if (state_q == ST_INSTR) begin
                            state_d = ST_INSTR_ACK;
                            pull_d  = 1'b1;
                            vld_d   = 1'b1;
                            idx_d   = IDX_INSTR;
                        end else begin
                            state_d = ST_WDATA_ACK;
                            pull_d  = 1'b1;
                            vld_d   = 1'b1;
                            idx_d   = IDX_DATA;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        pull_d  = 1'b0;
                        state_d = ST_INSTR;
                    end
                end
                ST_INSTR_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rd_sel_i) begin
                            state_d = ST_RDATA;
                            sh_d    = rd_data_i;
                            pull_d  = ~rd_data_i[DATA_W-1];
                            req_d   = 1'b1;
                        end else begin
                            state_d = ST_WDATA;
                            pull_d  = 1'b0;
                        end
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        pull_d  = 1'b0;
                        state_d = ST_HOLD;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt_q == CNT_LAST) begin
                            pull_d  = 1'b0;
                            state_d = ST_RD_MACK;
                        end else begin
                            sh_d   = {sh_q[DATA_W-2:0], 1'b0};
                            pull_d = ~sh_q[DATA_W-2];
                            cnt_d  = cnt_q + CNT_ONE;
                        end
                    end
                end
                ST_RD_MACK: begin
                    if (scl_fall) state_d = ST_HOLD;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            pull_q <= 1'b0;
            vld_q  <= 1'b0;
            req_q  <= 1'b0;
            byte_q <= '0;
            idx_q  <= IDX_ADDR;
        end else begin
            sh_q   <= sh_d;
            cnt_q  <= cnt_d;
            pull_q <= pull_d;
            vld_q  <= vld_d;
            req_q  <= req_d;
            byte_q <= byte_d;
            idx_q  <= idx_d;
        end
    end

    assign sda_pull_o = pull_q;
    assign rd_req_o   = req_q;
    assign byte_vld_o = vld_q;
    assign byte_o     = byte_q;
    assign byte_idx_o = idx_q;

    // R9: the open-drain pull never toggles while the filtered clock is high
    assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_q != $past(pull_q)) |-> !scl_f);

    // R5: entering the address acknowledge implies busy was low at the decision
    assert_busy_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR) |-> !$past(busy_i));

    // R10: a start always restarts the address phase with SDA released
    assert_start_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> (state_q == ST_ADDR && !pull_q));

    // R2: a stop always returns to idle
    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (state_q == ST_IDLE));

    // R8: the read request only coincides with the read shift phase
    assert_rdreq_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (state_q == ST_RDATA && cnt_q == '0));
endmodule

// File: rtl/tw_slave_fe.sv
module tw_slave_fe #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned STRAP_W     = 4,
    parameter int unsigned TYPE_ID     = 5,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic               rd_sel_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               rd_req_o,
    output logic               byte_vld_o,
    output logic [DATA_W-1:0]  byte_o,
    output logic [1:0]         byte_idx_o,
    output logic               start_o,
    output logic               stop_o
);
    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    logic       start_p, stop_p, scl_rise, scl_fall;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        twfe_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN),
            .IDLE_LEVEL (1'b1)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    twfe_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (filt_lines[1]),
        .sda_f   (filt_lines[0]),
        .start_p (start_p),
        .stop_p  (stop_p),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall)
    );

    twfe_fsm #(
        .DATA_W (DATA_W),
        .STRAP_W(STRAP_W),
        .TYPE_ID(TYPE_ID)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .scl_f     (filt_lines[1]),
        .sda_f     (filt_lines[0]),
        .strap_i   (strap_i),
        .busy_i    (busy_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_i (rd_data_i),
        .sda_pull_o(sda_pull_o),
        .rd_req_o  (rd_req_o),
        .byte_vld_o(byte_vld_o),
        .byte_o    (byte_o),
        .byte_idx_o(byte_idx_o)
    );

    assign start_o = start_p;
    assign stop_o  = stop_p;

    // R2: start and stop pulses never coincide
    assert_cond_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

// File: tb/tw_slave_fe_test.sv
module tw_slave_fe_test;
    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [3:0] strap = 4'h0;
    logic       busy = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       sda_pull, rd_req, byte_vld, start_p, stop_p;
    logic [7:0] byte_v;
    logic [1:0] byte_idx;
    logic       sda_line;

    int n_tests = 0, n_fail = 0;
    int vld_cnt = 0, start_cnt = 0, stop_cnt = 0, req_cnt = 0, r9_viol = 0;
    logic [7:0] last_byte = 8'h00;
    logic [1:0] last_idx = 2'd3;
    logic       prev_pull = 1'b0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    tw_slave_fe uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_i(strap), .busy_i(busy),
        .rd_sel_i(rd_sel), .rd_data_i(rd_data), .rd_req_o(rd_req),
        .byte_vld_o(byte_vld), .byte_o(byte_v), .byte_idx_o(byte_idx),
        .start_o(start_p), .stop_o(stop_p)
    );

    always @(negedge clk) begin
        if (byte_vld) begin vld_cnt++; last_byte = byte_v; last_idx = byte_idx; end
        if (start_p) start_cnt++;
        if (stop_p) stop_cnt++;
        if (rd_req) req_cnt++;
        if (sda_pull !== prev_pull && m_scl) r9_viol++;
        prev_pull = sda_pull;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ack(input logic [7:0] a, input logic [3:0] s, input bit bz);
        return (a == {4'b0101, s}) && !bz;
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        m_sda = b;
        if (glitch) begin
            wq(Q/2); m_scl = 1'b1; wq(1); m_scl = 1'b0; wq(Q - Q/2 - 1);
        end else wq(Q);
        m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic ninth(output logic ack_seen);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack_seen = ~sda_line;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input int glitch_bit, output logic ack_seen);
        for (int i = 7; i >= 0; i--) send_bit(v[i], (i == glitch_bit));
        ninth(ack_seen);
    endtask

    task automatic read_byte(output logic [7:0] v, output logic line_ninth);
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
            v = {v[6:0], sda_line};
            wq(Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        line_ninth = sda_line;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic ak, ln;
        logic [7:0] rv;
        int v0, s0, p0, r0;
        void'($urandom(32'h5EED1234));
        wq(5); rst_n = 1'b1; wq(5);
        check("R1 reset pull", sda_pull, 1'b0);
        check("R1 reset strobes", vld_cnt, 0);

        // R1: traffic without a start
        strap = 4'h3;
        m_scl = 1'b0; wq(Q);
        send_byte(8'h53, -1, ak);
        check("R1 no start ack", ak, 1'b0);
        check("R1 no start strobe", vld_cnt, 0);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);

        // R3 R6 R7 R2: write transaction
        s0 = start_cnt; p0 = stop_cnt;
        bus_start();
        check("R2 start pulse", start_cnt, s0 + 1);
        send_byte(8'h53, -1, ak);
        check("R3 addr ack", ak, 1'b1);
        check("R3 addr idx", last_idx, 2'd0);
        check("R3 addr byte", last_byte, 8'h53);
        send_byte(8'hC6, -1, ak);
        check("R6 instr ack", ak, 1'b1);
        check("R6 instr idx", last_idx, 2'd1);
        check("R6 instr byte", last_byte, 8'hC6);
        send_byte(8'h3A, -1, ak);
        check("R7 data ack", ak, 1'b1);
        check("R7 data idx", last_idx, 2'd2);
        check("R7 data byte", last_byte, 8'h3A);
        v0 = vld_cnt;
        send_byte(8'hFF, -1, ak);
        check("R7 extra byte ack", ak, 1'b0);
        check("R7 extra byte strobe", vld_cnt, v0);
        bus_stop();
        check("R2 stop pulse", stop_cnt, p0 + 1);

        // R4: mismatch
        strap = 4'h5;
        v0 = vld_cnt;
        bus_start();
        send_byte(8'h56, -1, ak);
        check("R4 mismatch ack", ak, 1'b0);
        send_byte(8'h55, -1, ak);
        check("R4 later byte ack", ak, 1'b0);
        check("R4 no strobe", vld_cnt, v0);
        bus_stop();

        // R5: polling while busy
        busy = 1'b1; v0 = vld_cnt;
        bus_start();
        send_byte(8'h55, -1, ak);
        check("R5 busy nack", ak, 1'b0);
        check("R5 busy no strobe", vld_cnt, v0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'h55, -1, ak);
        check("R5 ack after busy", ak, 1'b1);
        bus_stop();

        // R8: read
        rd_sel = 1'b1; rd_data = 8'hA6; r0 = req_cnt;
        bus_start();
        send_byte(8'h55, -1, ak);
        send_byte(8'hB1, -1, ak);
        check("R8 instr ack", ak, 1'b1);
        read_byte(rv, ln);
        check("R8 read data", rv, 8'hA6);
        check("R8 released ninth", ln, 1'b1);
        check("R8 one request", req_cnt, r0 + 1);
        bus_stop();
        rd_sel = 1'b0;

        // R10: repeated start mid-byte
        bus_start();
        send_byte(8'h55, -1, ak);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        bus_start();
        send_byte(8'h55, -1, ak);
        check("R10 re-addr ack", ak, 1'b1);
        check("R10 re-addr idx", last_idx, 2'd0);
        send_byte(8'h2D, -1, ak);
        check("R10 instr idx", last_idx, 2'd1);
        check("R10 instr byte", last_byte, 8'h2D);
        bus_stop();

        // R11: clock glitch
        bus_start();
        send_byte(8'h55, -1, ak);
        send_byte(8'h96, 3, ak);
        check("R11 glitch ack", ak, 1'b1);
        check("R11 glitch byte", last_byte, 8'h96);
        bus_stop();

        // random mix
        for (int it = 0; it < 24; it++) begin
            logic [7:0] a, ins, dat;
            logic bz, rd, ex;
            strap = 4'($urandom);
            bz = (($urandom % 4) == 0);
            rd = 1'($urandom);
            busy = bz; rd_sel = rd; rd_data = 8'($urandom);
            a = ($urandom % 2 == 1) ? {4'b0101, strap} : 8'($urandom);
            ins = 8'($urandom); dat = 8'($urandom);
            ex = exp_ack(a, strap, bz);
            v0 = vld_cnt;
            bus_start();
            send_byte(a, -1, ak);
            if (ex) begin
                check("R3 rand addr ack", ak, 1'b1);
                send_byte(ins, -1, ak);
                check("R6 rand instr ack", ak, 1'b1);
                check("R6 rand instr byte", last_byte, ins);
                if (rd) begin
                    read_byte(rv, ln);
                    check("R8 rand read", rv, rd_data);
                end else begin
                    send_byte(dat, -1, ak);
                    check("R7 rand data ack", ak, 1'b1);
                    check("R7 rand data byte", last_byte, dat);
                end
            end else if (a == {4'b0101, strap}) begin
                check("R5 rand busy nack", ak, 1'b0);
                check("R5 rand no strobe", vld_cnt, v0);
            end else begin
                check("R4 rand mismatch nack", ak, 1'b0);
                check("R4 rand no strobe", vld_cnt, v0);
            end
            bus_stop();
            busy = 1'b0;
        end

        check("R9 pull change with SCL high", r9_viol, 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule